// File: doc/BRIEF.md
# Host Direct Memory Access Port

This block lets an external host processor read and write a signal processor's on-chip program memory (24-bit words) and data memory (16-bit words) while the core keeps running. The host drives a single 16-bit bus that carries addresses and data at different times. An address-latch strobe marks an address phase, in which the bus carries a 14-bit memory address and a flag that selects program or data memory. A select strobe together with a read or write strobe marks a data phase. Every host strobe is asynchronous to the core clock. The port passes the strobes through two-flop synchronisers and turns each data phase into exactly one request on a single-cycle core memory interface.

After each complete access, the latched address moves on by one, so a block transfer needs only a starting address. A 24-bit program word takes two host accesses. The first carries the upper 16 bits and the second carries the low 8 bits in the lower byte of the bus. The port shields the memory-mapped control register window at the top of data memory from host writes. It also holds the core in a boot wait state until the host has written program location 0.

Top module: `host_mem_port`

## Requirements
- R1: While reset (synchronous, active low) is applied and just after it is released, `h_ack` is 1, `mem_req` is 0 and `h_ad_oe` is 0. `core_hold` equals `boot_from_host` as sampled during reset.
- R2: When the synchronised address strobe falls, the port captures the address from bus bits [13:0] and the memory space from bus bit 15 (1 = program, 0 = data). Bus bit 14 is ignored. The next data access uses that address and space.
- R3: After each complete access the latched address increases by one. In data space every access is complete. In program space only the second access of a pair is complete.
- R4: Take the core clock edges that follow the host asserting select plus read or write. `mem_req` is high for one cycle after the 3rd edge. `h_ack` is low after the 3rd and 4th edges and high again after the 5th.
- R5: A data-space write stores `{8'h00, bus}` at the latched address with `mem_space` = 0.
- R6: A data-space read returns the low 16 bits of the memory word on `h_ad_out`. `h_ad_oe` is high only while `h_ack` is high and a read strobe is held.
- R7: A program-space write pair issues no memory request on the first access and keeps its 16 bits. The second access issues one write of `{first 16 bits, bus[7:0]}`.
- R8: A program-space read pair fetches the whole word on the first access and returns bits [23:8]. The second access issues no memory request and returns `{8'h00, bits[7:0]}`.
- R9: A data-space write at an address of 0x3FE0 or above issues no memory request and leaves memory unchanged. The address still advances.
- R10: Once `core_hold` is 0 it stays 0 until the next reset. With `boot_from_host` = 1 it falls only when the second access of a program-space write pair at address 0 completes. Data writes to address 0 and program writes elsewhere do not release it.
- R11: A data-phase strobe held for any length of time produces exactly one memory request. A new access starts only after the strobes have been seen released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous reset, active low |
| boot_from_host | input | 1 | Boot-through-port mode, sampled during reset |
| h_ale | input | 1 | Host address-latch strobe, active high, asynchronous |
| h_sel_n | input | 1 | Host select, active low, asynchronous |
| h_rd_n | input | 1 | Host read strobe, active low, asynchronous |
| h_wr_n | input | 1 | Host write strobe, active low, asynchronous |
| h_ad_in | input | 16 | Host address/data bus, inbound |
| h_ad_out | output | 16 | Host data bus, outbound read data |
| h_ad_oe | output | 1 | Outbound bus drive enable |
| h_ack | output | 1 | Acknowledge: high when the port can take the next phase or read data is valid |
| mem_req | output | 1 | Core memory request, one cycle |
| mem_we | output | 1 | Request is a write |
| mem_space | output | 1 | Request space, 1 = program, 0 = data |
| mem_addr | output | 14 | Request address |
| mem_wdata | output | 24 | Write data |
| mem_rdata | input | 24 | Read data, valid the cycle after the request |
| core_hold | output | 1 | Holds core execution during host boot |

## Verification
The assertions assume the host follows its handshake. It keeps the bus stable for several core cycles after a strobe changes. It never raises the address strobe during a data phase. It keeps a data-phase strobe until `h_ack` returns and releases it before starting the next phase. The assertions also assume `boot_from_host` stays constant across a reset. The bench drives every host signal on the falling clock edge through tasks that wait for `h_ack` and add settling cycles around each phase. Its memory model answers one cycle after each request.

// File: rtl/hmp_pkg.sv
// Package: shared types for the host memory port.
// Assumes nothing beyond IEEE 1800-2017 enums.
package hmp_pkg;
    // Data-phase sequencer states.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,  // waiting for a phase; ack high
        ST_MEM  = 2'd1,  // memory request cycle
        ST_CAP  = 2'd2,  // capture read data, advance pointer
        ST_DONE = 2'd3   // ack high, waiting for host to release strobes
    } hmp_state_t;
endpackage

// File: rtl/hmp_sync.sv
// Module: multi-stage synchroniser for a vector of asynchronous strobes.
// Assumes each bit is an independent level that stays stable for at
// least STAGES core cycles; RST_VAL gives each bit's inactive level.
module hmp_sync #(
    parameter int unsigned        WIDTH   = 4,
    parameter int unsigned        STAGES  = 2,
    parameter logic [WIDTH-1:0]   RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);
    logic [WIDTH-1:0] stg [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            // One flop rank of the synchroniser chain.
            always_ff @(posedge clk) begin
                if (!rst_n) stg[g] <= RST_VAL;
                else if (g == 0) stg[g] <= d_async;
                else stg[g] <= stg[(g == 0) ? 0 : g - 1];
            end
        end
    endgenerate

    assign q_sync = stg[STAGES-1];
endmodule

// File: rtl/hmp_addr.sv
// Module: address and space latch with post-access increment.
// Assumes latch_en and inc_en are single-cycle pulses from the sequencer;
// a latch takes priority over an increment in the same cycle.
module hmp_addr #(
    parameter int unsigned ADDR_W = 14,
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              latch_en,
    input  logic              inc_en,
    input  logic [DATA_W-1:0] bus_in,
    output logic [ADDR_W-1:0] addr,
    output logic              space
);
    // Capture address/space on an address phase, advance after an access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr  <= '0;
            space <= 1'b0;
        end else if (latch_en) begin
            addr  <= bus_in[ADDR_W-1:0];
            space <= bus_in[DATA_W-1];
        end else if (inc_en) begin
            addr  <= addr + 1'b1;
        end
    end

    // R3: a lone increment advances the pointer by exactly one.
    a_r3_step_one: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_en && !latch_en) |=> (addr == ADDR_W'($past(addr) + 1'b1)));
endmodule

// File: rtl/hmp_ctrl.sv
// Module: data-phase sequencer, word assembly and boot hold.
// Assumes synchronised strobes, a memory that returns read data one
// cycle after mem_req, and a host that holds the bus stable during a phase.
module hmp_ctrl
    import hmp_pkg::*;
#(
    parameter int unsigned ADDR_W   = 14,
    parameter int unsigned DATA_W   = 16,
    parameter int unsigned PM_W     = 24,
    parameter int unsigned REG_BASE = 'h3FE0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              boot_mode,
    input  logic              s_ale,
    input  logic              s_sel_n,
    input  logic              s_rd_n,
    input  logic              s_wr_n,
    input  logic [DATA_W-1:0] bus_in,
    input  logic [ADDR_W-1:0] addr,
    input  logic              space,
    input  logic [PM_W-1:0]   mem_rdata,
    output logic              latch_en,
    output logic              inc_en,
    output logic              mem_req,
    output logic              mem_we,
    output logic              mem_space,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [PM_W-1:0]   mem_wdata,
    output logic [DATA_W-1:0] bus_out,
    output logic              bus_oe,
    output logic              ack,
    output logic              core_hold
);
    localparam int unsigned LO_W = PM_W - DATA_W;
    localparam int unsigned PAD_W = DATA_W - LO_W;
    localparam logic [ADDR_W-1:0] REG_BASE_A = ADDR_W'(REG_BASE);

    hmp_state_t        st;
    logic              ale_d;
    logic              is_rd;
    logic              half;
    logic              hold_q;
    logic [DATA_W-1:0] wd_q;
    logic [DATA_W-1:0] hi_q;
    logic [DATA_W-1:0] out_q;
    logic [LO_W-1:0]   lo_buf;

    logic strobe_on, strobe_off, ale_fall, need_mem, complete;

    // Phase detection from synchronised strobes.
    always_comb begin
        strobe_on  = !s_sel_n && (!s_rd_n || !s_wr_n);
        strobe_off = s_sel_n || (s_rd_n && s_wr_n);
        ale_fall   = ale_d && !s_ale;
    end

    // Decide whether this access touches memory and whether it completes a word.
    always_comb begin
        if (space) need_mem = is_rd ? !half : half;
        else       need_mem = is_rd || (addr < REG_BASE_A);
        complete = !space || half;
    end

    // Sequencer state, phase capture, word assembly and boot hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= ST_IDLE;
            ale_d  <= 1'b0;
            is_rd  <= 1'b0;
            half   <= 1'b0;
            hold_q <= boot_mode;
            wd_q   <= '0;
            hi_q   <= '0;
            out_q  <= '0;
            lo_buf <= '0;
        end else begin
            ale_d <= s_ale;
            if (latch_en) half <= 1'b0;
            unique case (st)
                ST_IDLE: if (strobe_on && !ale_fall) begin
                    is_rd <= !s_rd_n;
                    wd_q  <= bus_in;
                    st    <= ST_MEM;
                end
                ST_MEM: st <= ST_CAP;
                ST_CAP: begin
                    if (is_rd) begin
                        if (!space)     out_q <= mem_rdata[DATA_W-1:0];
                        else if (!half) begin
                            out_q  <= mem_rdata[PM_W-1:LO_W];
                            lo_buf <= mem_rdata[LO_W-1:0];
                        end else        out_q <= {{PAD_W{1'b0}}, lo_buf};
                    end else if (space && !half) begin
                        hi_q <= wd_q;
                    end
                    if (!is_rd && space && half && addr == '0) hold_q <= 1'b0;
                    half <= space ? !half : 1'b0;
                    st   <= ST_DONE;
                end
                ST_DONE: if (strobe_off) st <= ST_IDLE;
                default: st <= ST_IDLE;
            endcase
        end
    end

    // Outputs toward the memory and the host.
    always_comb begin
        latch_en  = ale_fall && (st == ST_IDLE);
        inc_en    = (st == ST_CAP) && complete;
        mem_req   = (st == ST_MEM) && need_mem;
        mem_we    = !is_rd;
        mem_space = space;
        mem_addr  = addr;
        mem_wdata = space ? {hi_q, wd_q[LO_W-1:0]} : {{LO_W{1'b0}}, wd_q};
        ack       = (st == ST_IDLE) || (st == ST_DONE);
        bus_oe    = (st == ST_DONE) && is_rd;
        bus_out   = out_q;
        core_hold = hold_q;
    end

    // R9: no host write ever reaches the control register window.
    a_r9_reg_window: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && !mem_space) |-> (mem_addr < REG_BASE_A));
    // R11: each data phase produces a single request cycle.
    a_r11_single_req: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);
    // R4: acknowledge is low while the memory is being accessed.
    a_r4_ack_low: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !ack);
    // R6: the port only drives the bus while acknowledging.
    a_r6_oe_with_ack: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe |-> ack);
    // R10: a released boot hold never returns before reset.
    a_r10_hold_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !core_hold |=> !core_hold);
endmodule

// File: rtl/host_mem_port.sv
// Module: top of the host memory port. Synchronises host strobes and
// joins the address latch to the sequencer.
// Assumes host strobes are asynchronous levels held per the handshake.
module host_mem_port #(
    parameter int unsigned ADDR_W   = 14,
    parameter int unsigned DATA_W   = 16,
    parameter int unsigned PM_W     = 24,
    parameter int unsigned SYNC_N   = 2,
    parameter int unsigned REG_BASE = 'h3FE0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              boot_from_host,
    input  logic              h_ale,
    input  logic              h_sel_n,
    input  logic              h_rd_n,
    input  logic              h_wr_n,
    input  logic [DATA_W-1:0] h_ad_in,
    output logic [DATA_W-1:0] h_ad_out,
    output logic              h_ad_oe,
    output logic              h_ack,
    output logic              mem_req,
    output logic              mem_we,
    output logic              mem_space,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [PM_W-1:0]   mem_wdata,
    input  logic [PM_W-1:0]   mem_rdata,
    output logic              core_hold
);
    localparam int unsigned NSTB = 4;

    logic [NSTB-1:0]   stb_sync;
    logic [ADDR_W-1:0] addr;
    logic              space;
    logic              latch_en, inc_en;

    hmp_sync #(.WIDTH(NSTB), .STAGES(SYNC_N), .RST_VAL(4'b0111)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async ({h_ale, h_sel_n, h_rd_n, h_wr_n}),
        .q_sync  (stb_sync)
    );

    hmp_addr #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .latch_en (latch_en),
        .inc_en   (inc_en),
        .bus_in   (h_ad_in),
        .addr     (addr),
        .space    (space)
    );

    hmp_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PM_W(PM_W), .REG_BASE(REG_BASE)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .boot_mode (boot_from_host),
        .s_ale     (stb_sync[3]),
        .s_sel_n   (stb_sync[2]),
        .s_rd_n    (stb_sync[1]),
        .s_wr_n    (stb_sync[0]),
        .bus_in    (h_ad_in),
        .addr      (addr),
        .space     (space),
        .mem_rdata (mem_rdata),
        .latch_en  (latch_en),
        .inc_en    (inc_en),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_space (mem_space),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .bus_out   (h_ad_out),
        .bus_oe    (h_ad_oe),
        .ack       (h_ack),
        .core_hold (core_hold)
    );
endmodule

// File: tb/tb_host_mem_port.sv
module tb_host_mem_port;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        boot_from_host = 1'b1;
    logic        h_ale = 1'b0, h_sel_n = 1'b1, h_rd_n = 1'b1, h_wr_n = 1'b1;
    logic [15:0] h_ad_in = '0;
    logic [15:0] h_ad_out;
    logic        h_ad_oe, h_ack, mem_req, mem_we, mem_space, core_hold;
    logic [13:0] mem_addr;
    logic [23:0] mem_wdata, mem_rdata;

    int n_chk = 0, n_bad = 0, req_cnt = 0;

    host_mem_port dut (
        .clk(clk), .rst_n(rst_n), .boot_from_host(boot_from_host),
        .h_ale(h_ale), .h_sel_n(h_sel_n), .h_rd_n(h_rd_n), .h_wr_n(h_wr_n),
        .h_ad_in(h_ad_in), .h_ad_out(h_ad_out), .h_ad_oe(h_ad_oe), .h_ack(h_ack),
        .mem_req(mem_req), .mem_we(mem_we), .mem_space(mem_space),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .core_hold(core_hold)
    );

    always #4 clk = ~clk;  // 125 MHz

    // Small memory models indexed by the low address byte.
    logic [23:0] pm [256];
    logic [15:0] dm [256];
    always @(posedge clk) begin
        if (rst_n && mem_req) begin
            req_cnt <= req_cnt + 1;
            if (mem_we) begin
                if (mem_space) pm[mem_addr[7:0]] <= mem_wdata;
                else           dm[mem_addr[7:0]] <= mem_wdata[15:0];
            end
            mem_rdata <= mem_space ? pm[mem_addr[7:0]] : {8'h00, dm[mem_addr[7:0]]};
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic host_addr(input logic sp, input logic [13:0] a);
        @(negedge clk);
        h_ad_in = {sp, 1'b0, a};
        h_ale = 1'b1;
        repeat (4) @(negedge clk);
        h_ale = 1'b0;
        repeat (5) @(negedge clk);
    endtask

    task automatic host_access(input logic rd, input logic [15:0] wd, output logic [15:0] rdv);
        @(negedge clk);
        h_ad_in = wd;
        h_sel_n = 1'b0;
        if (rd) h_rd_n = 1'b0; else h_wr_n = 1'b0;
        for (int k = 0; k < 20 && h_ack; k++) @(negedge clk);
        for (int k = 0; k < 20 && !h_ack; k++) @(negedge clk);
        rdv = h_ad_out;
        if (rd) check("R6 oe during read", {31'b0, h_ad_oe}, 32'd1);
        h_sel_n = 1'b1; h_rd_n = 1'b1; h_wr_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    // Vector: [40] set address, [39] space, [38] read, [37:24] addr, [23:0] data/expected.
    localparam int NV = 10;
    localparam logic [40:0] VEC [NV] = '{
        {1'b1, 1'b0, 1'b0, 14'h0010, 24'h001234},   // R5 data write
        {1'b0, 1'b0, 1'b0, 14'h0000, 24'h00BEEF},   // R3 lands at 0x0011
        {1'b1, 1'b0, 1'b1, 14'h0010, 24'h001234},   // R2 R6 read back
        {1'b0, 1'b0, 1'b1, 14'h0000, 24'h00BEEF},   // R3 increment
        {1'b1, 1'b1, 1'b0, 14'h0020, 24'hABCDEF},   // R7 program pair
        {1'b0, 1'b1, 1'b0, 14'h0000, 24'h123456},   // R3 lands at 0x0021
        {1'b1, 1'b1, 1'b1, 14'h0020, 24'hABCDEF},   // R8 program read
        {1'b0, 1'b1, 1'b1, 14'h0000, 24'h123456},   // R3 R8
        {1'b1, 1'b0, 1'b0, 14'h3FE0, 24'h005555},   // R9 protected write
        {1'b1, 1'b0, 1'b1, 14'h3FE0, 24'h0000A5}    // R9 unchanged
    };

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [15:0] r1, r2;
        logic [40:0] v;
        int c0;
        for (int i = 0; i < 256; i++) begin pm[i] = '0; dm[i] = '0; end
        dm[8'hE0] = 16'h00A5;
        mem_rdata = '0;
        repeat (5) @(negedge clk);
        check("R1 ack in reset", {31'b0, h_ack}, 32'd1);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 ack after reset", {31'b0, h_ack}, 32'd1);
        check("R1 no request", {31'b0, mem_req}, 32'd0);
        check("R1 oe low", {31'b0, h_ad_oe}, 32'd0);
        check("R1 R10 hold in boot mode", {31'b0, core_hold}, 32'd1);

        for (int i = 0; i < NV; i++) begin
            v = VEC[i];
            if (v[40]) host_addr(v[39], v[37:24]);
            if (v[39]) begin
                if (v[38]) begin
                    c0 = req_cnt;
                    host_access(1'b1, 16'h0, r1);
                    host_access(1'b1, 16'h0, r2);
                    check("R8 program word", {8'h0, r1, r2[7:0]}, {8'h0, v[23:0]});
                    check("R8 upper byte zero", {16'h0, r2}, {24'h0, v[7:0]});
                    check("R8 one fetch", c0 + 1, req_cnt);
                end else begin
                    host_access(1'b0, v[23:8], r1);
                    host_access(1'b0, {8'h00, v[7:0]}, r1);
                end
            end else begin
                if (v[38]) begin
                    host_access(1'b1, 16'h0, r1);
                    check("R2 R3 R5 R9 data read", {16'h0, r1}, {16'h0, v[15:0]});
                end else begin
                    host_access(1'b0, v[15:0], r1);
                end
            end
        end
        check("R7 pm word stored", {8'h0, pm[8'h20]}, 32'h00ABCDEF);
        check("R10 hold kept", {31'b0, core_hold}, 32'd1);

        // R4 / R11: latency and a strobe held far longer than needed.
        host_addr(1'b0, 14'h0030);
        c0 = req_cnt;
        @(negedge clk);
        h_ad_in = 16'h7777; h_sel_n = 1'b0; h_wr_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R4 ack low, req high", {30'b0, h_ack, mem_req}, 32'b01);
        @(negedge clk);
        check("R4 ack low after 4th edge", {31'b0, h_ack}, 32'd0);
        @(negedge clk);
        check("R4 ack back after 5th edge", {30'b0, h_ack, mem_req}, 32'b10);
        repeat (12) @(negedge clk);
        check("R11 one request for held strobe", req_cnt - c0, 32'd1);
        h_sel_n = 1'b1; h_wr_n = 1'b1;
        repeat (4) @(negedge clk);
        check("R5 data stored", {16'h0, dm[8'h30]}, 32'h7777);

        // R10: data write to 0 and a half pair at program 0 keep the hold.
        host_addr(1'b0, 14'h0000);
        host_access(1'b0, 16'h1111, r1);
        check("R10 data write 0 keeps hold", {31'b0, core_hold}, 32'd1);
        host_addr(1'b1, 14'h0000);
        host_access(1'b0, 16'h2233, r1);
        check("R10 first half keeps hold", {31'b0, core_hold}, 32'd1);
        host_access(1'b0, 16'h0044, r1);
        check("R10 hold released", {31'b0, core_hold}, 32'd0);
        check("R7 boot word", {8'h0, pm[0]}, 32'h00223344);

        // R1: reset without boot mode leaves the core free.
        @(negedge clk);
        rst_n = 1'b0; boot_from_host = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 hold clear without boot", {31'b0, core_hold}, 32'd0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule